// File: doc/BRIEF.md
# Tag-Snooping Reservation Station

This block holds a small pool of instructions waiting in front of one execution unit. Each slot stores an opcode, the rename tag of the result it will produce, and two source operands. A source is either a value that is already present, marked by tag 0, or a non-zero rename tag naming the result it still waits for. Dispatch logic writes new instructions into free slots and is refused through a full flag when no slot is free. Every cycle each waiting slot compares its pending tags with the tag on the completion bus and takes the value when they match. Because operands arrive this way, no register file read is needed for them.

When the execution unit signals that it can accept work, the station offers at most one slot whose two operands are both present. If several slots qualify, it offers the one dispatched earliest, whatever slot it sits in. A flush empties the whole pool in one cycle.

Each slot runs a three-state machine. `ENT_FREE` goes to `ENT_READY` when it is allocated with both operands present, counting a value captured in the same cycle, and goes to `ENT_WAIT` when it is allocated with an operand still missing. `ENT_WAIT` goes to `ENT_READY` once its last pending operand is captured. `ENT_READY` goes back to `ENT_FREE` when the slot is issued. Flush sends every state to `ENT_FREE`.

Top module: `rs_station`

## Requirements
- R1: After reset, `iss_valid` and `disp_full` are both 0.
- R2: An instruction dispatched with both source tags 0 is offered on the issue port from the next cycle, with its opcode, destination tag and the two dispatched values.
- R3: A slot waiting on a non-zero tag takes `cb_data` when `cb_valid` is high and `cb_tag` equals that tag, and it may issue from the next cycle. A broadcast with any other tag leaves the slot waiting.
- R4: When a dispatched source tag matches the completion bus in the dispatch cycle itself, the value is captured at dispatch and the operand is not missed.
- R5: A slot is offered only while both its operands are present. It leaves the pool only in a cycle where `iss_valid` and `iss_ready` are both 1. While `iss_ready` is 0 it stays offered.
- R6: At most one slot issues per cycle. Among slots that can issue, the earliest dispatched is chosen, regardless of slot position.
- R7: `disp_full` is 1 exactly when every slot is occupied. A dispatch offered while it is 1 is dropped and never issues.
- R8: A cycle with `flush` high empties every slot. In that cycle `iss_valid` is 0 and the dispatch input is ignored. In the next cycle `iss_valid` and `disp_full` are 0, and later broadcasts revive nothing.
- R9: Tag value 0 means "operand present". A completion broadcast carrying tag 0 does not change any stored operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty every slot |
| disp_valid | input | 1 | A dispatch is offered |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Destination rename tag |
| disp_t1 | input | TAG_W | Source 1 tag, 0 when the value is present |
| disp_v1 | input | DATA_W | Source 1 value, used when disp_t1 is 0 |
| disp_t2 | input | TAG_W | Source 2 tag, 0 when the value is present |
| disp_v2 | input | DATA_W | Source 2 value, used when disp_t2 is 0 |
| disp_full | output | 1 | No free slot, dispatch refused |
| cb_valid | input | 1 | Completion bus carries a result |
| cb_tag | input | TAG_W | Rename tag of the completed result |
| cb_data | input | DATA_W | Completed result value |
| iss_ready | input | 1 | Execution unit accepts an instruction |
| iss_valid | output | 1 | An instruction is offered |
| iss_op | output | OP_W | Offered opcode |
| iss_dst | output | TAG_W | Offered destination tag |
| iss_a | output | DATA_W | Offered source 1 value |
| iss_b | output | DATA_W | Offered source 2 value |

## Verification
The assertions assume three things about the inputs: reset is applied before use, the completion bus broadcasts each live tag at most once, and dispatched destination tags are non-zero and distinct among slots in flight. The stimulus stays within these limits. Every directed scenario picks its own fresh tags and drains or flushes the pool before the next scenario starts. The only tag-0 broadcast is in the scenario that checks it is ignored. Issue handshakes are driven between clock edges, so an offered slot leaves the pool only at the edge that follows an observed `iss_valid` and `iss_ready` pair.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_e;
endpackage

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry
    import rs_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int AGE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [OP_W-1:0]   d_op,
    input  logic [TAG_W-1:0]  d_dst,
    input  logic [TAG_W-1:0]  d_t1,
    input  logic [DATA_W-1:0] d_v1,
    input  logic [TAG_W-1:0]  d_t2,
    input  logic [DATA_W-1:0] d_v2,
    input  logic [AGE_W-1:0]  new_age,
    input  logic              cb_valid,
    input  logic [TAG_W-1:0]  cb_tag,
    input  logic [DATA_W-1:0] cb_data,
    input  logic              grant,
    input  logic              shift,
    input  logic [AGE_W-1:0]  issued_age,
    output logic              busy,
    output logic              ready,
    output logic [AGE_W-1:0]  age,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] v1,
    output logic [DATA_W-1:0] v2
);
    ent_state_e        state_q, state_d;
    logic [TAG_W-1:0]  t1_q, t2_q, n_t1, n_t2, s_t1, s_t2;
    logic [DATA_W-1:0] v1_q, v2_q, n_v1, n_v2, s_v1, s_v2;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q;
    logic [AGE_W-1:0]  age_q;

    // Operand source: fresh dispatch or stored, then snoop the bus.
    always_comb begin
        s_t1 = alloc ? d_t1 : t1_q;
        s_v1 = alloc ? d_v1 : v1_q;
        s_t2 = alloc ? d_t2 : t2_q;
        s_v2 = alloc ? d_v2 : v2_q;
        n_t1 = s_t1;
        n_v1 = s_v1;
        n_t2 = s_t2;
        n_v2 = s_v2;
        if (cb_valid && (s_t1 != '0) && (s_t1 == cb_tag)) begin
            n_t1 = '0;
            n_v1 = cb_data;
        end
        if (cb_valid && (s_t2 != '0) && (s_t2 == cb_tag)) begin
            n_t2 = '0;
            n_v2 = cb_data;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: begin
                if (alloc)
                    state_d = ((n_t1 == '0) && (n_t2 == '0)) ? ENT_READY : ENT_WAIT;
            end
            ENT_WAIT: begin
                if ((n_t1 == '0) && (n_t2 == '0))
                    state_d = ENT_READY;
            end
            ENT_READY: begin
                if (grant)
                    state_d = ENT_FREE;
            end
            default: state_d = ENT_FREE;
        endcase
        if (flush)
            state_d = ENT_FREE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ENT_FREE;
        else
            state_q <= state_d;
    end

    // Payload and age registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_q  <= '0;
            t2_q  <= '0;
            v1_q  <= '0;
            v2_q  <= '0;
            op_q  <= '0;
            dst_q <= '0;
            age_q <= '0;
        end else begin
            if (alloc || (state_q == ENT_WAIT)) begin
                t1_q <= n_t1;
                v1_q <= n_v1;
                t2_q <= n_t2;
                v2_q <= n_v2;
            end
            if (alloc) begin
                op_q  <= d_op;
                dst_q <= d_dst;
                age_q <= new_age;
            end else if (shift && (state_q != ENT_FREE) && (age_q > issued_age)) begin
                age_q <= age_q - 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy  = (state_q != ENT_FREE);
        ready = (state_q == ENT_READY);
        age   = age_q;
        op    = op_q;
        dst   = dst_q;
        v1    = v1_q;
        v2    = v2_q;
    end

    // R5: a slot in the ready state holds no pending tag.
    p_ready_ops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_READY) |-> ((t1_q == '0) && (t2_q == '0)));
endmodule

// File: rtl/rs_alloc.sv
`timescale 1ns/1ps
module rs_alloc #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ENT-1:0] busy,
    output logic               full,
    output logic [IDX_W-1:0]   idx
);
    logic found;

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!busy[i] && !found) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
        full = !found;
    end
endmodule

// File: rtl/rs_select.sv
`timescale 1ns/1ps
module rs_select #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2,
    parameter int AGE_W   = 2
) (
    input  logic [NUM_ENT-1:0] ready,
    input  logic [AGE_W-1:0]   ages [NUM_ENT],
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    logic [AGE_W-1:0] best;
    logic             found;

    always_comb begin
        idx   = '0;
        best  = '1;
        found = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (ready[i] && (!found || (ages[i] < best))) begin
                idx   = IDX_W'(i);
                best  = ages[i];
                found = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/rs_station.sv
`timescale 1ns/1ps
module rs_station #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 16,
    parameter int OP_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic [TAG_W-1:0]  disp_t1,
    input  logic [DATA_W-1:0] disp_v1,
    input  logic [TAG_W-1:0]  disp_t2,
    input  logic [DATA_W-1:0] disp_v2,
    output logic              disp_full,
    input  logic              cb_valid,
    input  logic [TAG_W-1:0]  cb_tag,
    input  logic [DATA_W-1:0] cb_data,
    input  logic              iss_ready,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam int AGE_W = IDX_W;
    localparam int CNT_W = $clog2(NUM_ENT + 1);

    logic [NUM_ENT-1:0] busy, ready;
    logic [AGE_W-1:0]   ages [NUM_ENT];
    logic [OP_W-1:0]    ops  [NUM_ENT];
    logic [TAG_W-1:0]   dsts [NUM_ENT];
    logic [DATA_W-1:0]  va   [NUM_ENT];
    logic [DATA_W-1:0]  vb   [NUM_ENT];

    logic               full, gnt_any, disp_fire, iss_fire;
    logic [IDX_W-1:0]   alloc_idx, gnt_idx;
    logic [CNT_W-1:0]   busy_cnt;
    logic [AGE_W-1:0]   new_age;

    rs_alloc #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_alloc (
        .busy (busy),
        .full (full),
        .idx  (alloc_idx)
    );

    rs_select #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_select (
        .ready (ready),
        .ages  (ages),
        .any   (gnt_any),
        .idx   (gnt_idx)
    );

    always_comb begin
        busy_cnt = '0;
        for (int i = 0; i < NUM_ENT; i++)
            busy_cnt = busy_cnt + CNT_W'(busy[i]);
    end

    assign disp_full = full;
    assign disp_fire = disp_valid && !full && !flush;
    assign iss_valid = gnt_any && !flush;
    assign iss_fire  = iss_valid && iss_ready;
    assign new_age   = AGE_W'(busy_cnt - CNT_W'(iss_fire));

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        rs_entry #(
            .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .AGE_W(AGE_W)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .alloc      (disp_fire && (alloc_idx == IDX_W'(g))),
            .d_op       (disp_op),
            .d_dst      (disp_dst),
            .d_t1       (disp_t1),
            .d_v1       (disp_v1),
            .d_t2       (disp_t2),
            .d_v2       (disp_v2),
            .new_age    (new_age),
            .cb_valid   (cb_valid),
            .cb_tag     (cb_tag),
            .cb_data    (cb_data),
            .grant      (iss_fire && (gnt_idx == IDX_W'(g))),
            .shift      (iss_fire),
            .issued_age (ages[gnt_idx]),
            .busy       (busy[g]),
            .ready      (ready[g]),
            .age        (ages[g]),
            .op         (ops[g]),
            .dst        (dsts[g]),
            .v1         (va[g]),
            .v2         (vb[g])
        );
    end

    assign iss_op  = ops[gnt_idx];
    assign iss_dst = dsts[gnt_idx];
    assign iss_a   = va[gnt_idx];
    assign iss_b   = vb[gnt_idx];

    // R8: after a flush cycle the pool is empty.
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!iss_valid && !disp_full));

    // R6: outside a flush, at most one slot leaves per cycle.
    p_one_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ($countones($past(busy) & ~busy) <= 1));

    // R7: an accepted dispatch always lands in an unoccupied slot.
    p_alloc_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> !busy[alloc_idx]);
endmodule

// File: tb/test_rs_station.sv
`timescale 1ns/1ps
module test_rs_station;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic [3:0]  disp_op = '0, disp_dst = '0, disp_t1 = '0, disp_t2 = '0;
    logic [15:0] disp_v1 = '0, disp_v2 = '0;
    logic        disp_full;
    logic        cb_valid = 1'b0;
    logic [3:0]  cb_tag = '0;
    logic [15:0] cb_data = '0;
    logic        iss_ready = 1'b0;
    logic        iss_valid;
    logic [3:0]  iss_op, iss_dst;
    logic [15:0] iss_a, iss_b;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rs_station i_rs_station (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_t1(disp_t1), .disp_v1(disp_v1), .disp_t2(disp_t2), .disp_v2(disp_v2),
        .disp_full(disp_full),
        .cb_valid(cb_valid), .cb_tag(cb_tag), .cb_data(cb_data),
        .iss_ready(iss_ready), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic set_disp(input int op, input int dst, input int t1,
                            input int v1, input int t2, input int v2);
        disp_valid = 1'b1;
        disp_op  = 4'(op);
        disp_dst = 4'(dst);
        disp_t1  = 4'(t1);
        disp_v1  = 16'(v1);
        disp_t2  = 4'(t2);
        disp_v2  = 16'(v2);
    endtask

    task automatic disp(input int op, input int dst, input int t1,
                        input int v1, input int t2, input int v2);
        set_disp(op, dst, t1, v1, t2, v2);
        step();
        disp_valid = 1'b0;
    endtask

    task automatic bcast(input int tag, input int data);
        cb_valid = 1'b1;
        cb_tag   = 4'(tag);
        cb_data  = 16'(data);
        step();
        cb_valid = 1'b0;
    endtask

    task automatic pop();
        iss_ready = 1'b1;
        step();
        iss_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "iss_valid after reset", 32'(iss_valid), 0);
        chk("R1", "disp_full after reset", 32'(disp_full), 0);
    endtask

    task automatic t_ready_dispatch();
        disp(3, 5, 0, 11, 0, 22);
        chk("R2", "iss_valid", 32'(iss_valid), 1);
        chk("R2", "iss_op", 32'(iss_op), 3);
        chk("R2", "iss_dst", 32'(iss_dst), 5);
        chk("R2", "iss_a", 32'(iss_a), 11);
        chk("R2", "iss_b", 32'(iss_b), 22);
        pop();
        chk("R2", "iss_valid after issue", 32'(iss_valid), 0);
    endtask

    task automatic t_snoop();
        disp(2, 6, 7, 0, 0, 5);
        chk("R3", "waiting not offered", 32'(iss_valid), 0);
        bcast(8, 99);
        chk("R3", "other tag ignored", 32'(iss_valid), 0);
        bcast(7, 44);
        chk("R3", "offered after match", 32'(iss_valid), 1);
        chk("R3", "captured a", 32'(iss_a), 44);
        chk("R3", "kept b", 32'(iss_b), 5);
        pop();
        chk("R3", "empty after issue", 32'(iss_valid), 0);
    endtask

    task automatic t_same_cycle();
        set_disp(1, 9, 9, 0, 0, 1);
        cb_valid = 1'b1;
        cb_tag   = 4'd9;
        cb_data  = 16'd77;
        step();
        disp_valid = 1'b0;
        cb_valid   = 1'b0;
        chk("R4", "offered after same-cycle capture", 32'(iss_valid), 1);
        chk("R4", "captured a", 32'(iss_a), 77);
        chk("R4", "kept b", 32'(iss_b), 1);
        pop();
    endtask

    task automatic t_hold();
        iss_ready = 1'b1;
        disp(1, 7, 10, 0, 0, 3);
        step();
        chk("R5", "pending operand blocks issue", 32'(iss_valid), 0);
        bcast(10, 55);
        chk("R5", "offered once complete", 32'(iss_valid), 1);
        chk("R5", "issued a", 32'(iss_a), 55);
        chk("R5", "issued dst", 32'(iss_dst), 7);
        step();
        chk("R5", "removed by handshake", 32'(iss_valid), 0);
        iss_ready = 1'b0;
        disp(1, 8, 0, 1, 0, 2);
        step();
        step();
        chk("R5", "held while unit busy", 32'(iss_valid), 1);
        chk("R5", "held dst", 32'(iss_dst), 8);
        pop();
        chk("R5", "gone after handshake", 32'(iss_valid), 0);
    endtask

    task automatic t_oldest();
        disp(0, 4, 0, 1, 0, 1);
        disp(0, 1, 12, 0, 0, 2);
        disp(0, 2, 0, 3, 0, 3);
        disp(0, 3, 0, 4, 0, 4);
        chk("R7", "full with all slots used", 32'(disp_full), 1);
        chk("R6", "oldest ready offered", 32'(iss_dst), 4);
        disp(0, 9, 0, 9, 0, 9);
        chk("R7", "still full after refused dispatch", 32'(disp_full), 1);
        pop();
        chk("R7", "not full after issue", 32'(disp_full), 0);
        chk("R6", "skips waiting older slot", 32'(iss_dst), 2);
        disp(0, 5, 0, 5, 0, 5);
        chk("R7", "full again", 32'(disp_full), 1);
        bcast(12, 66);
        iss_ready = 1'b1;
        chk("R6", "order 1st", 32'(iss_dst), 1);
        chk("R3", "first a", 32'(iss_a), 66);
        step();
        chk("R6", "order 2nd", 32'(iss_dst), 2);
        step();
        chk("R6", "order 3rd", 32'(iss_dst), 3);
        step();
        chk("R6", "order 4th youngest in low slot", 32'(iss_dst), 5);
        step();
        chk("R7", "refused dispatch never issues", 32'(iss_valid), 0);
        iss_ready = 1'b0;
    endtask

    task automatic t_flush();
        disp(0, 1, 13, 0, 0, 0);
        disp(0, 2, 0, 4, 0, 4);
        chk("R8", "offered before flush", 32'(iss_valid), 1);
        flush = 1'b1;
        set_disp(0, 3, 0, 6, 0, 6);
        #0.1;
        chk("R8", "no offer during flush", 32'(iss_valid), 0);
        step();
        flush = 1'b0;
        disp_valid = 1'b0;
        chk("R8", "empty after flush", 32'(iss_valid), 0);
        chk("R8", "not full after flush", 32'(disp_full), 0);
        bcast(13, 5);
        chk("R8", "broadcast revives nothing", 32'(iss_valid), 0);
    endtask

    task automatic t_tag0();
        disp(0, 4, 0, 33, 0, 44);
        bcast(0, 1234);
        chk("R9", "offered", 32'(iss_valid), 1);
        chk("R9", "a untouched by tag 0", 32'(iss_a), 33);
        chk("R9", "b untouched by tag 0", 32'(iss_b), 44);
        pop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ready_dispatch();
        t_snoop();
        t_same_cycle();
        t_hold();
        t_oldest();
        t_flush();
        t_tag0();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule